// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects interrupt requests from five maskable sources of a small 8-bit microcontroller: external request 0, timer 0 overflow, external request 1, timer 1 overflow, and the serial port. It presents one request line and a 16-bit handler address to the CPU. Software writes an 8-bit enable register and an 8-bit priority register. The priority register places each source in either the high level or the low level. Inside a level, a fixed polling order picks the winner.

The CPU pulses `irq_ack` when it accepts the request and the address shown at that moment. It pulses `irq_ret` when the handler returns. On acceptance, a timer or external source has its pending flag cleared by hardware. The serial flag is the OR of a receive flag and a transmit flag, and only `ser_clr` clears it. Two in-service bits, one per level, are tracked by a four-state machine:

- `ISV_NONE`: nothing is in service.
- `ISV_LOW`: a low-level handler is in service.
- `ISV_HIGH`: a high-level handler is in service, with no low handler under it.
- `ISV_NEST`: a high-level handler has preempted a low-level one.

The state machine has these transitions:

- `ISV_NONE` goes to `ISV_HIGH` when a high request is taken, and to `ISV_LOW` when a low request is taken.
- `ISV_LOW` goes to `ISV_NEST` when a high request is taken, and to `ISV_NONE` on return.
- `ISV_HIGH` goes to `ISV_NONE` on return.
- `ISV_NEST` goes to `ISV_LOW` on return.

A request is presented only when its level is above every level in service.

Top module: `intc_two_level`

## Requirements
- R1: After reset, every enable bit is 0, including the global bit, so `irq_req` stays low whatever flags are pending.
- R2: Enable register bit 7 is the global enable. Bits 0..4 enable external 0, timer 0, external 1, timer 1 and serial, in that order. A source is requested only when both its own bit and bit 7 are 1.
- R3: Priority register bits 0..4 map to the sources in the same order as the enable register. A 1 puts the source in the high level and a 0 in the low level. Any enabled high-level request wins over every low-level request.
- R4: Among pending requests of the same level, the winner is the first in the order external 0, timer 0, external 1, timer 1, serial.
- R5: The vector is 0x0003 for external 0, 0x000B for timer 0, 0x0013 for external 1, 0x001B for timer 1, and 0x0023 for serial.
- R6: When a request is taken (`irq_ack` while `irq_req`), the pending flag of an external or timer source clears. The serial flag stays set until `ser_clr`.
- R7: While a low handler is in service, low-level requests are held off, and a high-level request is still presented.
- R8: While a high handler is in service, no request is presented.
- R9: `irq_ret` removes the high in-service level if it is set, otherwise the low one.
- R10: A flag raised while its source is disabled stays pending, and it is requested once the source is enabled.
- R11: The serial request is pending when either the receive flag or the transmit flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register write data |
| pri_we | input | 1 | Write strobe for the priority register |
| pri_wdata | input | 8 | Priority register write data |
| ext0_set | input | 1 | Pulse that sets the external 0 flag |
| tmr0_set | input | 1 | Pulse that sets the timer 0 overflow flag |
| ext1_set | input | 1 | Pulse that sets the external 1 flag |
| tmr1_set | input | 1 | Pulse that sets the timer 1 overflow flag |
| ser_rx_set | input | 1 | Pulse that sets the serial receive flag |
| ser_tx_set | input | 1 | Pulse that sets the serial transmit flag |
| ser_clr | input | 1 | Software clear of both serial flags |
| irq_ack | input | 1 | CPU accepts the presented request |
| irq_ret | input | 1 | Handler return pulse |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | 16 | Handler address of the presented request |

## Verification
The bench builds the block with its default parameters: five sources, 8-bit registers, a 16-bit vector, base 0x0003 and stride 8. These defaults are the exact register bit positions and addresses that the requirements name. With them, every state of the in-service machine can be reached, including a high handler nested on a low one. They also allow a full five-source collision to be drained one handler at a time, which exercises the polling order. Serial preemption can be driven from either of its two flags.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic [1:0] {
        ISV_NONE = 2'd0,
        ISV_LOW  = 2'd1,
        ISV_HIGH = 2'd2,
        ISV_NEST = 2'd3
    } isv_state_e;
endpackage

// File: rtl/intc_pend.sv
module intc_pend #(
    parameter int N_SRC = 5,
    localparam int IDX_W = $clog2(N_SRC),
    localparam int SER_IDX = N_SRC - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-2:0] hw_set,
    input  logic             ser_rx_set,
    input  logic             ser_tx_set,
    input  logic             ser_clr,
    input  logic             take,
    input  logic [IDX_W-1:0] take_idx,
    output logic [N_SRC-1:0] pend
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (i == SER_IDX) begin : g_ser
            logic rx_q, tx_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rx_q <= 1'b0;
                    tx_q <= 1'b0;
                end else if (ser_clr) begin
                    rx_q <= 1'b0;
                    tx_q <= 1'b0;
                end else begin
                    if (ser_rx_set) rx_q <= 1'b1;
                    if (ser_tx_set) tx_q <= 1'b1;
                end
            end
            assign pend[i] = rx_q | tx_q;

            // R6: taking the serial request leaves its flag alone
            a_r6_serial_kept: assert property (@(posedge clk) disable iff (!rst_n)
                (pend[i] && !ser_clr) |=> pend[i]);
        end else begin : g_hw
            logic flag_q;
            logic hit;
            assign hit = take && (take_idx == IDX_W'(i));
            always_ff @(posedge clk) begin
                if (!rst_n)          flag_q <= 1'b0;
                else if (hw_set[i])  flag_q <= 1'b1;
                else if (hit)        flag_q <= 1'b0;
            end
            assign pend[i] = flag_q;

            // R6: acceptance clears a timer or external flag
            a_r6_hw_cleared: assert property (@(posedge clk) disable iff (!rst_n)
                (hit && !hw_set[i]) |=> !pend[i]);
        end
    end
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
    parameter int N_SRC = 5,
    parameter int VEC_W = 16,
    parameter logic [VEC_W-1:0] VEC_BASE = 16'h0003,
    parameter int VEC_STRIDE = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] src_en,
    input  logic             glb_en,
    input  logic [N_SRC-1:0] lvl_hi,
    output logic             win_vld,
    output logic             win_hi,
    output logic [IDX_W-1:0] win_idx,
    output logic [VEC_W-1:0] win_vec
);
    logic [N_SRC-1:0] live, hi_req, lo_req, pick;

    always_comb begin
        live    = pend & src_en & {N_SRC{glb_en}};
        hi_req  = live & lvl_hi;
        lo_req  = live & ~lvl_hi;
        win_hi  = |hi_req;
        pick    = win_hi ? hi_req : lo_req;
        win_vld = |pick;
        win_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pick[i]) win_idx = IDX_W'(i);
        end
        win_vec = VEC_BASE + VEC_W'(VEC_STRIDE) * VEC_W'(win_idx);
    end
endmodule

// File: rtl/intc_isv.sv
module intc_isv
    import intc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic take_hi,
    input  logic ret,
    output logic allow_hi,
    output logic allow_lo,
    output logic isv_hi,
    output logic isv_lo
);
    isv_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ISV_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ISV_NONE: if (take)                state_d = take_hi ? ISV_HIGH : ISV_LOW;
            ISV_LOW:  if (ret)                 state_d = ISV_NONE;
                      else if (take && take_hi) state_d = ISV_NEST;
            ISV_HIGH: if (ret)                 state_d = ISV_NONE;
            ISV_NEST: if (ret)                 state_d = ISV_LOW;
        endcase
    end

    always_comb begin
        allow_hi = 1'b0;
        allow_lo = 1'b0;
        isv_hi   = 1'b0;
        isv_lo   = 1'b0;
        unique case (state_q)
            ISV_NONE: begin allow_hi = 1'b1; allow_lo = 1'b1; end
            ISV_LOW:  begin allow_hi = 1'b1; isv_lo = 1'b1; end
            ISV_HIGH: isv_hi = 1'b1;
            ISV_NEST: begin isv_hi = 1'b1; isv_lo = 1'b1; end
        endcase
    end

    // R9: return from a nested high handler falls back to the low one
    a_r9_nest_ret_low: assert property (@(posedge clk) disable iff (!rst_n)
        (isv_hi && isv_lo && ret) |=> (isv_lo && !isv_hi));
    // R9: return from a lone high handler leaves nothing in service
    a_r9_high_ret_none: assert property (@(posedge clk) disable iff (!rst_n)
        (isv_hi && !isv_lo && ret) |=> (!isv_hi && !isv_lo));
    // R7: a low handler can only be stacked on by a high one
    a_r7_low_no_low_take: assert property (@(posedge clk) disable iff (!rst_n)
        (isv_lo && !isv_hi && take && !ret) |-> take_hi);
endmodule

// File: rtl/intc_two_level.sv
module intc_two_level #(
    parameter int N_SRC = 5,
    parameter int REG_W = 8,
    parameter int GLB_BIT = 7,
    parameter int VEC_W = 16,
    parameter logic [VEC_W-1:0] VEC_BASE = 16'h0003,
    parameter int VEC_STRIDE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_we,
    input  logic [REG_W-1:0] en_wdata,
    input  logic             pri_we,
    input  logic [REG_W-1:0] pri_wdata,
    input  logic             ext0_set,
    input  logic             tmr0_set,
    input  logic             ext1_set,
    input  logic             tmr1_set,
    input  logic             ser_rx_set,
    input  logic             ser_tx_set,
    input  logic             ser_clr,
    input  logic             irq_ack,
    input  logic             irq_ret,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec
);
    localparam int IDX_W = $clog2(N_SRC);

    logic [REG_W-1:0] en_q, pri_q;
    logic [N_SRC-1:0] pend;
    logic             win_vld, win_hi;
    logic [IDX_W-1:0] win_idx;
    logic             allow_hi, allow_lo, isv_hi, isv_lo;
    logic             take;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pri_q <= '0;
        end else begin
            if (en_we)  en_q  <= en_wdata;
            if (pri_we) pri_q <= pri_wdata;
        end
    end

    logic unused_reg_bits;
    assign unused_reg_bits = ^{pri_q[REG_W-1:N_SRC], en_q[REG_W-1:N_SRC]};

    intc_pend #(.N_SRC(N_SRC)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_set     ({tmr1_set, ext1_set, tmr0_set, ext0_set}),
        .ser_rx_set (ser_rx_set),
        .ser_tx_set (ser_tx_set),
        .ser_clr    (ser_clr),
        .take       (take),
        .take_idx   (win_idx),
        .pend       (pend)
    );

    intc_arb #(
        .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
    ) u_arb (
        .pend    (pend),
        .src_en  (en_q[N_SRC-1:0]),
        .glb_en  (en_q[GLB_BIT]),
        .lvl_hi  (pri_q[N_SRC-1:0]),
        .win_vld (win_vld),
        .win_hi  (win_hi),
        .win_idx (win_idx),
        .win_vec (irq_vec)
    );

    assign irq_req = win_vld && (win_hi ? allow_hi : allow_lo);
    assign take    = irq_ack && irq_req && !irq_ret;

    intc_isv u_isv (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .take_hi  (win_hi),
        .ret      (irq_ret),
        .allow_hi (allow_hi),
        .allow_lo (allow_lo),
        .isv_hi   (isv_hi),
        .isv_lo   (isv_lo)
    );

    // R1 / R2: global enable off means no request
    a_r1_global_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[GLB_BIT] |-> !irq_req);
    // R8: a high handler in service blocks every request
    a_r8_high_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
        isv_hi |-> !irq_req);
    // R7: under a low handler only high-level requests are shown
    a_r7_low_shows_high: assert property (@(posedge clk) disable iff (!rst_n)
        (isv_lo && irq_req) |-> win_hi);
    // R5: presented vectors sit on the stride grid above the base
    a_r5_vec_grid: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (((irq_vec - VEC_BASE) % VEC_W'(VEC_STRIDE)) == '0));
endmodule

// File: tb/tb_intc_two_level.sv
module tb_intc_two_level;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_we = 1'b0, pri_we = 1'b0;
    logic [7:0]  en_wdata = '0, pri_wdata = '0;
    logic        ext0_set = 0, tmr0_set = 0, ext1_set = 0, tmr1_set = 0;
    logic        ser_rx_set = 0, ser_tx_set = 0, ser_clr = 0;
    logic        irq_ack = 0, irq_ret = 0;
    logic        irq_req;
    logic [15:0] irq_vec;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct { logic [15:0] vec; string tag; } item_t;
    item_t exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    intc_two_level dut (
        .clk(clk), .rst_n(rst_n),
        .en_we(en_we), .en_wdata(en_wdata), .pri_we(pri_we), .pri_wdata(pri_wdata),
        .ext0_set(ext0_set), .tmr0_set(tmr0_set), .ext1_set(ext1_set), .tmr1_set(tmr1_set),
        .ser_rx_set(ser_rx_set), .ser_tx_set(ser_tx_set), .ser_clr(ser_clr),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_req(input logic exp, input string tag);
        check(irq_req === exp, tag, {16'h0, irq_req}, {16'h0, exp});
    endtask

    // monitor: pops an expected vector whenever the driver acknowledges
    always @(negedge clk) begin
        #1;
        if (irq_ack) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard empty", {irq_req, irq_vec}, '0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(irq_req === 1'b1 && irq_vec === it.vec, it.tag,
                      {irq_req, irq_vec}, {1'b1, it.vec});
            end
        end
    end

    task automatic take(input logic [15:0] v, input string tag);
        item_t it;
        it.vec = v;
        it.tag = tag;
        exp_q.push_back(it);
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    task automatic ret();
        irq_ret = 1'b1;
        tick();
        irq_ret = 1'b0;
    endtask

    task automatic wr_en(input logic [7:0] v);
        en_we = 1'b1; en_wdata = v; tick(); en_we = 1'b0;
    endtask

    task automatic wr_pri(input logic [7:0] v);
        pri_we = 1'b1; pri_wdata = v; tick(); pri_we = 1'b0;
    endtask

    // m bits: 0 ext0, 1 tmr0, 2 ext1, 3 tmr1, 4 serial receive; tx = serial transmit
    task automatic raise(input logic [4:0] m, input logic tx);
        {ser_rx_set, tmr1_set, ext1_set, tmr0_set, ext0_set} = m;
        ser_tx_set = tx;
        tick();
        {ser_rx_set, tmr1_set, ext1_set, tmr0_set, ext0_set} = '0;
        ser_tx_set = 1'b0;
    endtask

    task automatic sclr();
        ser_clr = 1'b1; tick(); ser_clr = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: flags pending but nothing enabled
        check_req(1'b0, "R1 reset idle");
        raise(5'b10001, 1'b0);
        check_req(1'b0, "R1 no request after reset with flags pending");

        // R2: source bit without global bit
        wr_en(8'h01);
        check_req(1'b0, "R2 source enabled, global off");
        wr_en(8'h81);
        take(16'h0003, "R2 R5 ext0 taken with global on");
        ret();
        check_req(1'b0, "R6 ext0 flag cleared on take");
        sclr();

        // R4: all five pending at low level
        wr_en(8'h9F);
        wr_pri(8'h00);
        raise(5'b11111, 1'b0);
        take(16'h0003, "R4 first ext0");
        check_req(1'b0, "R7 low in service blocks low");
        ret();
        take(16'h000B, "R4 second tmr0");
        ret();
        take(16'h0013, "R4 third ext1");
        ret();
        take(16'h001B, "R4 fourth tmr1");
        ret();
        take(16'h0023, "R4 R5 fifth serial");
        ret();
        check_req(1'b1, "R6 serial flag still set after take");
        check(irq_vec === 16'h0023, "R6 serial vector kept", {1'b0, irq_vec}, {1'b0, 16'h0023});
        sclr();
        check_req(1'b0, "R6 ser_clr removes serial request");

        // R3 / R11: serial high via transmit flag beats ext0 low
        wr_pri(8'h10);
        raise(5'b00001, 1'b1);
        take(16'h0023, "R3 R11 high serial over low ext0");
        check_req(1'b0, "R8 high in service blocks low ext0");
        sclr();
        ret();
        take(16'h0003, "R9 ext0 after high returns");
        raise(5'b01000, 1'b0);
        check_req(1'b0, "R7 low tmr1 held under low handler");
        raise(5'b10000, 1'b0);
        take(16'h0023, "R7 high serial preempts low handler");
        sclr();
        raise(5'b00100, 1'b0);
        check_req(1'b0, "R8 nested high blocks ext1");
        ret();
        check_req(1'b0, "R9 first return leaves low in service");
        ret();
        take(16'h0013, "R9 R4 ext1 before tmr1 after both returns");
        ret();
        take(16'h001B, "R4 tmr1 last");
        ret();
        check_req(1'b0, "R6 all hardware flags drained");

        // R10: pending while disabled
        wr_en(8'h80);
        raise(5'b00010, 1'b0);
        repeat (3) tick();
        check_req(1'b0, "R10 tmr0 pending while disabled");
        wr_en(8'h82);
        take(16'h000B, "R10 tmr0 taken once enabled");
        ret();
        check_req(1'b0, "R10 tmr0 cleared after take");

        tick();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule